// File: doc/BRIEF.md
# Interrupt Cause, Acknowledge and Mask Unit

This unit collects single-cycle event pulses from the internal engines of a network controller and records each one as a sticky cause bit in a 16-bit status word. The host reaches the unit through a small byte-wide register port with read and write strobes. From that port it reads the status word, clears causes by writing ones to the upper status byte, and masks the interrupt line or raises a software interrupt through a control byte.

The single interrupt output is a level signal. It is the registered OR of the six latched causes, gated by the mask bit. The low status byte shows the live state of the command and receive engines, taken from input pins. The port carries no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `irq_status_unit`

## Requirements
- R1: After reset all causes are clear, the mask bit is 1, `irq_o` is 0 and `host_rdata_o` is 0x00.
- R2: A pulse on an event input sets its cause. The causes appear in the byte at offset 1 as follows: command done bit 7 (status bit 15), frame received bit 6, command unit idle bit 5, receive unit stalled bit 4, management done bit 3, software interrupt bit 2 (status bit 10). Bits 1:0 of that byte read 0.
- R3: A cause stays set until the host acknowledges it.
- R4: A write to offset 1 clears every cause whose bit is written as 1 and leaves the causes written as 0 unchanged.
- R5: When an event and an acknowledge of the same cause fall in the same cycle, the cause stays set.
- R6: Offset 3 is the control byte. A write with bit 1 set sets the software-interrupt cause. Reads of offset 3 return the mask in bit 0, and bit 1 reads as 0.
- R7: `irq_o` is a register equal to the OR of the causes, gated by the inverted mask. It changes at the same clock edge as the causes and the mask that feed it.
- R8: Writing the mask bit as 1 deasserts `irq_o` at that edge and keeps the latched causes. Clearing the mask again reasserts `irq_o` while any cause is set.
- R9: Offset 0 reads `{cu_state_i, ru_state_i}`. Offset 2 reads 0x00. Writes to offsets 0 and 2 have no effect.
- R10: `host_rdata_o` loads the addressed byte at the edge where `host_rd_i` is high, and it holds its value while `host_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_done_i | input | 1 | Event: command executed |
| rx_frame_i | input | 1 | Event: frame received |
| cu_idle_i | input | 1 | Event: command unit went idle |
| ru_stall_i | input | 1 | Event: receive unit not ready |
| mgmt_done_i | input | 1 | Event: management register access done |
| cu_state_i | input | 2 | Command unit state, shown in status bits 7:6 |
| ru_state_i | input | 6 | Receive unit state, shown in status bits 5:0 |
| host_addr_i | input | 2 | Byte offset of the register access |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
Causes, mask and `irq_o` all update at the edge that samples the event or the write strobe, so the bench checks `irq_o` at the falling edge that follows that edge. Read data takes one more edge: the bench raises `host_rd_i`, lets one rising edge pass, and compares `host_rdata_o` at the next falling edge. The bench drives all inputs on falling edges, so there is no race at the rising edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CAUSES = 6;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 2;
  // cause vector index (also hi-byte bit minus 2)
  localparam int C_SWI = 0;
  localparam int C_MGT = 1;
  localparam int C_RUS = 2;
  localparam int C_CUI = 3;
  localparam int C_RXF = 4;
  localparam int C_CMD = 5;
  localparam int PAD_W = REG_W - NUM_CAUSES;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATE = 2'd0,
    OFS_CAUSE = 2'd1,
    OFS_RSVD  = 2'd2,
    OFS_CTRL  = 2'd3
  } reg_ofs_e;

  localparam int CTRL_MASK_BIT = 0;
  localparam int CTRL_SWI_BIT  = 1;
endpackage

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic cause_o,
  output logic cause_next_o
);
  logic q;

  always_comb begin
    if (set_i)      cause_next_o = 1'b1;
    else if (clr_i) cause_next_o = 1'b0;
    else            cause_next_o = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= cause_next_o;
  end

  assign cause_o = q;

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> cause_o);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o && !clr_i) |=> cause_o);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !cause_o);
endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
  import irq_pkg::*;
#(
  parameter int CU_W = 2,
  parameter int RU_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [NUM_CAUSES-1:0] cause_i,
  input  logic [CU_W-1:0]       cu_state_i,
  input  logic [RU_W-1:0]       ru_state_i,
  output logic [NUM_CAUSES-1:0] ack_o,
  output logic                  swi_o,
  output logic                  mask_o,
  output logic                  mask_next_o,
  output logic [REG_W-1:0]      rdata_o
);
  localparam int STATE_W = CU_W + RU_W;

  logic            mask_q;
  logic            ctrl_wr;
  logic [REG_W-1:0] rd_mux;
  logic [STATE_W-1:0] state_byte;

  assign state_byte  = {cu_state_i, ru_state_i};
  assign ctrl_wr     = wr_i && (addr_i == OFS_CTRL);
  assign swi_o       = ctrl_wr && wdata_i[CTRL_SWI_BIT];
  assign ack_o       = (wr_i && (addr_i == OFS_CAUSE)) ? wdata_i[REG_W-1:PAD_W]
                                                      : '0;
  assign mask_next_o = ctrl_wr ? wdata_i[CTRL_MASK_BIT] : mask_q;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFS_STATE: rd_mux = REG_W'(state_byte);
      OFS_CAUSE: rd_mux = {cause_i, {PAD_W{1'b0}}};
      OFS_CTRL:  rd_mux[CTRL_MASK_BIT] = mask_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b1;
      rdata_o <= '0;
    end else begin
      mask_q <= mask_next_o;
      if (rd_i) rdata_o <= rd_mux;
    end
  end

  assign mask_o = mask_q;

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
  p_ctrl_swi_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == OFS_CTRL) |=> !rdata_o[CTRL_SWI_BIT]);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int CU_W = 2,
  parameter int RU_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_done_i,
  input  logic                  rx_frame_i,
  input  logic                  cu_idle_i,
  input  logic                  ru_stall_i,
  input  logic                  mgmt_done_i,
  input  logic [CU_W-1:0]       cu_state_i,
  input  logic [RU_W-1:0]       ru_state_i,
  input  logic [ADDR_W-1:0]     host_addr_i,
  input  logic                  host_wr_i,
  input  logic                  host_rd_i,
  input  logic [REG_W-1:0]      host_wdata_i,
  output logic [REG_W-1:0]      host_rdata_o,
  output logic                  irq_o
);
  logic [NUM_CAUSES-1:0] ev, ack, cause_q, cause_d;
  logic swi, mask_q, mask_d, irq_q;

  assign ev[C_CMD] = cmd_done_i;
  assign ev[C_RXF] = rx_frame_i;
  assign ev[C_CUI] = cu_idle_i;
  assign ev[C_RUS] = ru_stall_i;
  assign ev[C_MGT] = mgmt_done_i;
  assign ev[C_SWI] = swi;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
    irq_cause_bit i_bit (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (ev[g]),
      .clr_i        (ack[g]),
      .cause_o      (cause_q[g]),
      .cause_next_o (cause_d[g])
    );
  end

  irq_host_port #(.CU_W(CU_W), .RU_W(RU_W)) i_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (host_addr_i),
    .wr_i        (host_wr_i),
    .rd_i        (host_rd_i),
    .wdata_i     (host_wdata_i),
    .cause_i     (cause_q),
    .cu_state_i  (cu_state_i),
    .ru_state_i  (ru_state_i),
    .ack_o       (ack),
    .swi_o       (swi),
    .mask_o      (mask_q),
    .mask_next_o (mask_d),
    .rdata_o     (host_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|cause_d) && !mask_d;
  end

  assign irq_o = irq_q;

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_o);
  p_irq_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cause_q != '0));
  p_irq_when_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q != '0) && !mask_q) |-> irq_o);
  p_same_cycle_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[C_CMD] && ack[C_CMD]) |=> cause_q[C_CMD]);
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_done_i = 0, rx_frame_i = 0, cu_idle_i = 0, ru_stall_i = 0, mgmt_done_i = 0;
  logic [1:0] cu_state_i = 2'b10;
  logic [5:0] ru_state_i = 6'h15;
  logic [1:0] host_addr_i = 0;
  logic host_wr_i = 0, host_rd_i = 0;
  logic [7:0] host_wdata_i = 0;
  logic [7:0] host_rdata_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_status_unit i_irq_status_unit (.*);

  // {events cmd,rx,cuidle,rustall,mgmt ; wr ; addr ; wdata ; expected cause byte ; expected irq}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {5'b00000, 1'b1, 2'd3, 8'h00, 8'h00, 1'b0},  // R8 unmask
    {5'b10000, 1'b0, 2'd0, 8'h00, 8'h80, 1'b1},  // R2 R7
    {5'b01001, 1'b0, 2'd0, 8'h00, 8'hC8, 1'b1},  // R2 R3
    {5'b00000, 1'b1, 2'd1, 8'h80, 8'h48, 1'b1},  // R4
    {5'b00010, 1'b1, 2'd1, 8'h58, 8'h10, 1'b1},  // R5
    {5'b00000, 1'b1, 2'd3, 8'h01, 8'h10, 1'b0},  // R8 mask
    {5'b00100, 1'b0, 2'd0, 8'h00, 8'h30, 1'b0},  // R8 latched while masked
    {5'b00000, 1'b1, 2'd3, 8'h00, 8'h30, 1'b1},  // R8 unmask
    {5'b00000, 1'b1, 2'd3, 8'h02, 8'h34, 1'b1},  // R6
    {5'b00000, 1'b1, 2'd1, 8'h34, 8'h00, 1'b0},  // R4 R7
    {5'b00000, 1'b1, 2'd0, 8'hFF, 8'h00, 1'b0},  // R9
    {5'b11111, 1'b1, 2'd1, 8'h00, 8'hF8, 1'b1},  // R2
    {5'b00000, 1'b1, 2'd1, 8'hFF, 8'h00, 1'b0},  // R4
    {5'b00000, 1'b1, 2'd3, 8'h03, 8'h04, 1'b0},  // R6 R8
    {5'b00000, 1'b1, 2'd1, 8'h04, 8'h00, 1'b0}   // R4
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr_i = a; host_rd_i = 1;
    @(negedge clk);
    host_rd_i = 0;
    d = host_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    host_addr_i = a; host_wdata_i = v; host_wr_i = 1;
    @(negedge clk);
    host_wr_i = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    check("R1 rdata", host_rdata_o, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd(2'd3, d); check("R1 mask after reset", d, 8'h01);
    rd(2'd1, d); check("R1 causes after reset", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {cmd_done_i, rx_frame_i, cu_idle_i, ru_stall_i, mgmt_done_i} = VEC[i][24:20];
      host_wr_i = VEC[i][19]; host_addr_i = VEC[i][18:17]; host_wdata_i = VEC[i][16:9];
      @(negedge clk);
      {cmd_done_i, rx_frame_i, cu_idle_i, ru_stall_i, mgmt_done_i} = '0;
      host_wr_i = 0;
      check($sformatf("R7 vec %0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][0]});
      rd(2'd1, d);
      check($sformatf("R2 vec %0d cause byte", i), d, VEC[i][8:1]);
    end

    // R9 unit state byte and write ignore
    rd(2'd0, d); check("R9 state read", d, 8'h95);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R9 state after write", d, 8'h95);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R9 offset 2", d, 8'h00);
    // R6 control readback
    wr(2'd3, 8'h03);
    rd(2'd3, d); check("R6 ctrl readback", d, 8'h01);
    wr(2'd1, 8'hFF);
    // R10 hold without strobe
    wr(2'd3, 8'h00);
    cmd_done_i = 1; @(negedge clk); cmd_done_i = 0;
    @(negedge clk);
    check("R10 rdata hold", host_rdata_o, 8'h01);
    check("R7 irq on event", {7'b0, irq_o}, 8'h01);
    // R5 event vs ack same cycle on command-done bit
    cmd_done_i = 1; host_wr_i = 1; host_addr_i = 2'd1; host_wdata_i = 8'h80;
    @(negedge clk);
    cmd_done_i = 0; host_wr_i = 0;
    rd(2'd1, d); check("R5 event wins", d, 8'h80);
    // R1 reset mid operation
    rst_n = 0; #1;
    check("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    @(negedge clk); rst_n = 1; @(negedge clk);
    rd(2'd1, d); check("R1 causes cleared", d, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule